// File: doc/BRIEF.md
# Register and I/O Transfer Executor

This block carries out the data-move instructions of a small 8-bit controller that do not use pointer-based addressing. It holds a 32-entry register file of 8-bit registers. It accepts one 16-bit instruction word per transfer. It moves bytes between registers, a byte-addressed data space and a 16-bit-wide program memory.

The block handles six kinds of transfer. It loads an 8-bit constant into an upper register. It copies one register to another. It swaps the two nibbles of a register. It reads and writes I/O ports, which appear in the data space starting at address 0x20. It loads and stores bytes at a direct 16-bit data address, which is carried in a second instruction word. It loads one byte from program memory, addressed by the 16-bit pointer made from registers 31 (high byte) and 30 (low byte). Fetch sequencing stays outside the block. The block raises `ready` when it can take a new word, asks for the second word with `need_word2`, and pulses `done` in the last cycle of each instruction.

The data space answers reads combinationally, in the same cycle as `dmem_re`. The program memory returns its word one cycle after `pmem_re`.

Top module: `xfer_exec`

## Requirements
- R1: A word with bits 15:12 = 1110 writes register 16 + bits 7:4 with the constant {bits 11:8, bits 3:0}. It completes (`done`=1) in its accept cycle.
- R2: A word with bits 15:10 = 001011 copies register {bit 9, bits 3:0} into register bits 8:4. It completes in its accept cycle.
- R3: A word with bits 15:9 = 1001010 and bits 3:0 = 0010 swaps the high and low nibbles of register bits 8:4. It completes in its accept cycle.
- R4: A word with bits 15:11 = 10110 forms port number p = {bits 10:9, bits 3:0}. In its accept cycle it asserts `dmem_re` at address 0x20 + p, and it writes the returned byte into register bits 8:4.
- R5: A word with bits 15:11 = 10111 asserts `dmem_we` at address 0x20 + p in its accept cycle, with `dmem_wdata` equal to register bits 8:4.
- R6: A word with bits 15:9 = 1001000 (load) or 1001001 (store) and bits 3:0 = 0000 raises `need_word2` from the cycle after acceptance until `word2_valid` is seen. The access to address `word2` happens in the next cycle, together with `done`. For a load, register bits 8:4 takes `dmem_rdata`. For a store, `dmem_wdata` is register bits 8:4. With no wait, the transfer takes three cycles.
- R7: The word 0x95C8 asserts `pmem_re` at address {r31, r30} in its accept cycle. In the third cycle it writes register 0 and pulses `done`. It writes the high byte of the returned word when r30 bit 0 is 1, and the low byte otherwise.
- R8: Any other word raises `illegal` together with `done` in its accept cycle. It writes no register and makes no data-space or program-memory access.
- R9: After reset all registers read 0 and `ready` is 1. `ready` is 1 exactly when the block is idle, and `instr_valid` is only taken while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| ready | output | 1 | Idle; next word is accepted |
| done | output | 1 | Last cycle of an instruction |
| illegal | output | 1 | Unrecognised encoding |
| need_word2 | output | 1 | Waiting for the address word |
| word2_valid | input | 1 | Address word present |
| word2 | input | 16 | Direct data address |
| dmem_addr | output | 16 | Data-space address |
| dmem_re | output | 1 | Data-space read |
| dmem_we | output | 1 | Data-space write |
| dmem_wdata | output | 8 | Data-space write byte |
| dmem_rdata | input | 8 | Data-space read byte, same cycle |
| pmem_addr | output | 16 | Program-memory word address |
| pmem_re | output | 1 | Program-memory read |
| pmem_rdata | input | 16 | Program-memory word, one cycle later |

## Verification
The register file can only be seen through stores, so a corrupted register stays hidden until an I/O output or direct store names it. The bench therefore sweeps every register through output instructions, both after reset and after a long random run. A wrong sequencer state shows up within one or two cycles as a missing or early `done`, a `need_word2` outside a direct transfer, or a program-memory byte written one cycle too soon. A wrong byte-select latch shows up only when register 0 is later stored, so the bench compares that store against the pointer's parity.

// File: rtl/xfer_exec.sv
module xfer_exec #(
  parameter logic [15:0] IO_BASE = 16'h0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr,
  output logic        ready,
  output logic        done,
  output logic        illegal,
  output logic        need_word2,
  input  logic        word2_valid,
  input  logic [15:0] word2,
  output logic [15:0] dmem_addr,
  output logic        dmem_re,
  output logic        dmem_we,
  output logic [7:0]  dmem_wdata,
  input  logic [7:0]  dmem_rdata,
  output logic [15:0] pmem_addr,
  output logic        pmem_re,
  input  logic [15:0] pmem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT2, S_ACC, S_PM1, S_PM2} st_t;

  st_t        st, st_nx;
  logic [7:0] rf [32];
  logic [4:0] reg_q;
  logic       ld_q;
  logic [15:0] adr_q;
  logic       sel_q;
  logic [7:0] byte_q;
  logic       rf_we;
  logic [4:0] rf_wa;
  logic [7:0] rf_wd;

  wire        acc     = instr_valid && (st == S_IDLE);
  wire [4:0]  fd      = instr[8:4];
  wire [4:0]  fs      = {instr[9], instr[3:0]};
  wire [5:0]  port    = {instr[10:9], instr[3:0]};
  wire [15:0] io_adr  = IO_BASE + {10'd0, port};
  wire        is_ldi  = instr[15:12] == 4'b1110;
  wire        is_mov  = instr[15:10] == 6'b001011;
  wire        is_in   = instr[15:11] == 5'b10110;
  wire        is_out  = instr[15:11] == 5'b10111;
  wire        is_swap = (instr[15:9] == 7'b1001010) && (instr[3:0] == 4'h2);
  wire        is_dir  = (instr[15:10] == 6'b100100) && (instr[3:0] == 4'h0);
  wire        is_lpm  = instr == 16'h95C8;

  assign ready = st == S_IDLE;

  always_comb begin
    st_nx      = st;
    done       = 1'b0;
    illegal    = 1'b0;
    need_word2 = 1'b0;
    dmem_addr  = 16'h0000;
    dmem_re    = 1'b0;
    dmem_we    = 1'b0;
    dmem_wdata = 8'h00;
    pmem_addr  = 16'h0000;
    pmem_re    = 1'b0;
    rf_we      = 1'b0;
    rf_wa      = 5'd0;
    rf_wd      = 8'h00;
    case (st)
      S_IDLE: if (acc) begin
        done = !(is_dir || is_lpm);
        if (is_ldi) begin
          rf_we = 1'b1;
          rf_wa = {1'b1, instr[7:4]};
          rf_wd = {instr[11:8], instr[3:0]};
        end else if (is_mov) begin
          rf_we = 1'b1;
          rf_wa = fd;
          rf_wd = rf[fs];
        end else if (is_swap) begin
          rf_we = 1'b1;
          rf_wa = fd;
          rf_wd = {rf[fd][3:0], rf[fd][7:4]};
        end else if (is_in) begin
          dmem_re   = 1'b1;
          dmem_addr = io_adr;
          rf_we     = 1'b1;
          rf_wa     = fd;
          rf_wd     = dmem_rdata;
        end else if (is_out) begin
          dmem_we    = 1'b1;
          dmem_addr  = io_adr;
          dmem_wdata = rf[fd];
        end else if (is_dir) begin
          st_nx = S_WAIT2;
        end else if (is_lpm) begin
          pmem_re   = 1'b1;
          pmem_addr = {rf[31], rf[30]};
          st_nx     = S_PM1;
        end else begin
          illegal = 1'b1;
        end
      end
      S_WAIT2: begin
        need_word2 = 1'b1;
        if (word2_valid) st_nx = S_ACC;
      end
      S_ACC: begin
        dmem_addr = adr_q;
        done      = 1'b1;
        st_nx     = S_IDLE;
        if (ld_q) begin
          dmem_re = 1'b1;
          rf_we   = 1'b1;
          rf_wa   = reg_q;
          rf_wd   = dmem_rdata;
        end else begin
          dmem_we    = 1'b1;
          dmem_wdata = rf[reg_q];
        end
      end
      S_PM1: st_nx = S_PM2;
      S_PM2: begin
        rf_we = 1'b1;
        rf_wa = 5'd0;
        rf_wd = byte_q;
        done  = 1'b1;
        st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      reg_q  <= 5'd0;
      ld_q   <= 1'b0;
      adr_q  <= 16'h0000;
      sel_q  <= 1'b0;
      byte_q <= 8'h00;
      for (int i = 0; i < 32; i++) rf[i] <= 8'h00;
    end else begin
      st <= st_nx;
      if (acc && is_dir) begin
        reg_q <= fd;
        ld_q  <= !instr[9];
      end
      if (acc && is_lpm) sel_q <= rf[30][0];
      if (st == S_WAIT2 && word2_valid) adr_q <= word2;
      if (st == S_PM1) byte_q <= sel_q ? pmem_rdata[15:8] : pmem_rdata[7:0];
      if (rf_we) rf[rf_wa] <= rf_wd;
    end
  end

  // R6
  w2_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need_word2 |-> !ready);

  // R6
  w2_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need_word2 && word2_valid) |=> (done && (dmem_re || dmem_we) && dmem_addr == $past(word2)));

  // R7
  pm_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_re |=> (!done && !ready) ##1 (done && !dmem_we && !dmem_re));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && ready && !dmem_we && !dmem_re && !pmem_re));

  // R4
  io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready && (dmem_re || dmem_we)) |-> (dmem_addr >= IO_BASE && dmem_addr <= IO_BASE + 16'd63));

  // R9
  done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ready) |=> ready);
endmodule

// File: tb/sim_xfer_exec.sv
module sim_xfer_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        word2_valid = 1'b0;
  logic [15:0] word2 = 16'h0000;
  logic        ready, done, illegal, need_word2, dmem_re, dmem_we, pmem_re;
  logic [15:0] dmem_addr, pmem_addr;
  logic [7:0]  dmem_wdata, dmem_rdata;
  logic [15:0] pmem_rdata = 16'h0000;

  xfer_exec u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ready(ready), .done(done), .illegal(illegal), .need_word2(need_word2),
    .word2_valid(word2_valid), .word2(word2), .dmem_addr(dmem_addr),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .pmem_addr(pmem_addr), .pmem_re(pmem_re),
    .pmem_rdata(pmem_rdata)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [15:0] pmf(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
  endfunction

  assign dmem_rdata = memf(dmem_addr);
  always @(posedge clk) if (pmem_re) pmem_rdata <= pmf(pmem_addr);

  logic [7:0] m [32];
  int checks = 0;
  int fails = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic start(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    instr_valid = 1'b1;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1 instr_valid = 1'b0;
  endtask

  task automatic op_ldi(input logic [3:0] d, input logic [7:0] k);
    start({4'hE, k[7:4], d, k[3:0]});
    chk("R1 done", {done, illegal}, 2'b10);
    tick();
    m[{1'b1, d}] = k;
  endtask

  task automatic op_mov(input logic [4:0] d, input logic [4:0] r);
    start({6'b001011, r[4], d, r[3:0]});
    chk("R2 done", done, 1'b1);
    tick();
    m[d] = m[r];
  endtask

  task automatic op_swap(input logic [4:0] d);
    start({7'b1001010, d, 4'h2});
    chk("R3 done", done, 1'b1);
    tick();
    m[d] = {m[d][3:0], m[d][7:4]};
  endtask

  task automatic op_in(input logic [4:0] d, input logic [5:0] p);
    start({5'b10110, p[5:4], d, p[3:0]});
    chk("R4 read", {done, dmem_re, dmem_we, dmem_addr}, {3'b110, 16'h0020 + 16'(p)});
    tick();
    m[d] = memf(16'h0020 + 16'(p));
  endtask

  task automatic op_out(input logic [4:0] r, input logic [5:0] p);
    start({5'b10111, p[5:4], r, p[3:0]});
    chk("R5 write", {done, dmem_we, dmem_re, dmem_addr, dmem_wdata},
        {3'b110, 16'h0020 + 16'(p), m[r]});
    tick();
  endtask

  task automatic op_dir(input logic st, input logic [4:0] d, input logic [15:0] a, input int gap);
    start({6'b100100, st, d, 4'h0});
    chk("R6 accept", {done, ready}, 2'b01);
    tick();
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); #1;
      chk("R6 wait", {need_word2, done}, 2'b10);
    end
    @(negedge clk);
    word2 = a;
    word2_valid = 1'b1;
    #1 chk("R6 need", need_word2, 1'b1);
    @(posedge clk);
    #1 word2_valid = 1'b0;
    @(negedge clk); #1;
    if (st) chk("R6 store", {done, dmem_we, dmem_re, dmem_addr, dmem_wdata}, {3'b110, a, m[d]});
    else    chk("R6 load", {done, dmem_re, dmem_we, dmem_addr}, {3'b110, a});
    @(posedge clk); #1;
    if (!st) m[d] = memf(a);
  endtask

  task automatic op_lpm();
    logic [15:0] z;
    logic [15:0] w;
    z = {m[31], m[30]};
    w = pmf(z);
    start(16'h95C8);
    chk("R7 addr", {pmem_re, pmem_addr, done}, {1'b1, z, 1'b0});
    tick();
    @(negedge clk); #1 chk("R7 mid", done, 1'b0);
    @(negedge clk); #1 chk("R7 end", done, 1'b1);
    @(posedge clk); #1;
    m[0] = z[0] ? w[15:8] : w[7:0];
  endtask

  task automatic op_bad(input logic [15:0] w);
    start(w);
    chk("R8 flag", {illegal, done, dmem_we, dmem_re, pmem_re}, 5'b11000);
    tick();
  endtask

  task automatic sweep();
    for (int r = 0; r < 32; r++) op_out(5'(r), 6'($urandom % 64));
  endtask

  logic [15:0] bad [4] = '{16'h0000, 16'hFFFF, 16'h9001, 16'h95C9};

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset ready", {ready, done, need_word2}, 3'b100);
    sweep();
    op_ldi(4'd0, 8'hFF);
    op_ldi(4'd15, 8'h00);
    op_ldi(4'd15, 8'hA5);
    op_mov(5'd1, 5'd31);
    op_mov(5'd2, 5'd16);
    op_swap(5'd31);
    op_in(5'd3, 6'd0);
    op_in(5'd4, 6'd63);
    op_out(5'd4, 6'd63);
    op_dir(1'b0, 5'd5, 16'hFFFF, 0);
    op_dir(1'b0, 5'd6, 16'h1234, 3);
    op_dir(1'b1, 5'd5, 16'h0000, 0);
    op_dir(1'b1, 5'd31, 16'hBEEF, 2);
    op_ldi(4'd14, 8'h01);
    op_ldi(4'd15, 8'h80);
    op_lpm();
    op_out(5'd0, 6'd1);
    op_ldi(4'd14, 8'h02);
    op_lpm();
    op_out(5'd0, 6'd2);
    for (int i = 0; i < 4; i++) op_bad(bad[i]);
    sweep();
    for (int n = 0; n < 500; n++) begin
      case ($urandom % 9)
        0: op_ldi(4'($urandom), 8'($urandom));
        1: op_mov(5'($urandom), 5'($urandom));
        2: op_swap(5'($urandom));
        3: op_in(5'($urandom), 6'($urandom));
        4: op_out(5'($urandom), 6'($urandom));
        5: op_dir(1'b0, 5'($urandom), 16'($urandom), int'($urandom % 3));
        6: op_dir(1'b1, 5'($urandom), 16'($urandom), int'($urandom % 3));
        7: op_lpm();
        default: op_bad(bad[$urandom % 4]);
      endcase
    end
    sweep();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule